// File: doc/BRIEF.md
# ADC Result Window Comparator

This block watches the stream of conversion results coming out of an ADC and compares every new result against two programmable 16-bit limits: an upper bound called the above-limit and a lower bound called the below-limit. When the result meets the window condition, a sticky match flag is set. The flag stays set until it is cleared. It can be polled directly, or it can reach the interrupt controller through an enable gate.

The relative order of the two limits selects the sense of the window. No mode bit is involved.

- When the below-limit is strictly greater than the above-limit, the flag reports results that lie strictly between the two limits (inside mode).
- Otherwise, the flag reports results that lie below the below-limit or above the above-limit (outside mode).

Software loads the limits one byte at a time through a small write port. A new value becomes part of the comparison at the next result strobe. No CPU action is needed for each conversion.

Top module: `adc_window_cmp`

## Requirements
- R1: After a synchronous active-low reset, the match flag is 0, the above-limit is 0xFFFF and the below-limit is 0x0000. With these limits no result can set the flag.
- R2: A write with `lim_wr_en` high stores `lim_wr_data` into the byte selected by `lim_wr_addr`. Address 0 is the above-limit bits 7:0, address 1 is the above-limit bits 15:8, address 2 is the below-limit bits 7:0, and address 3 is the below-limit bits 15:8.
- R3: When below-limit > above-limit (inside mode), a strobed result sets the flag exactly when above-limit < result < below-limit. A result equal to either limit does not match.
- R4: When below-limit <= above-limit (outside mode), a strobed result sets the flag exactly when result < below-limit or result > above-limit.
- R5: The result is compared only in a cycle where `res_valid` is high. Data presented without the strobe never sets the flag.
- R6: The flag is set on the clock edge that samples a matching strobed result. Once set, it holds until a cycle with `flag_clr` high, and it reads 0 after that edge.
- R7: When `flag_clr` is high in the same cycle as a matching strobed result, the flag ends up set.
- R8: A limit byte written in the same cycle as a result strobe does not affect that strobe's comparison. It does apply to the next strobe.
- R9: `win_irq` equals the flag ANDed with `irq_en`, with no added delay.
- R10: When both limits are equal, the block is in outside mode, so every result except the shared limit value matches.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| res_data | input | 16 | Conversion result word |
| res_valid | input | 1 | One-cycle strobe marking a new result |
| lim_wr_en | input | 1 | Limit byte write enable |
| lim_wr_addr | input | 2 | Limit byte select (see R2) |
| lim_wr_data | input | 8 | Byte to write |
| flag_clr | input | 1 | Clears the sticky match flag |
| irq_en | input | 1 | Interrupt enable |
| win_flag | output | 1 | Sticky window match flag |
| win_irq | output | 1 | Interrupt request, flag gated by enable |

## Verification
The limits are programmed in both inside and outside orderings, and also with both limits equal. Results sit exactly on each limit, one step past each limit, and well clear of the window, which separates strict comparisons from inclusive ones and separates the two window senses. Three further patterns isolate the timing rules: data without a strobe, a clear coinciding with a match, and a limit write in the same cycle as a strobe. A long run of pseudo-random results, limit writes and clears is then compared against a behavioural model on every clock.

// File: rtl/adc_win_pkg.sv
// Package: shared constants and types for the ADC window comparator.
// Assumes limits are stored as an array indexed by the constants below.
package adc_win_pkg;
    localparam int LIM_ABOVE = 0;   // index of the upper (greater-than) limit
    localparam int LIM_BELOW = 1;   // index of the lower (less-than) limit
    localparam int NUM_LIMS  = 2;

    typedef enum logic {
        WIN_OUTSIDE = 1'b0,
        WIN_INSIDE  = 1'b1
    } win_mode_e;
endpackage

// File: rtl/adc_win_limits.sv
// Module: byte-addressed storage for the two window limits.
// Byte address = limit_index * bytes_per_limit + byte_index (low byte first).
// Assumes DATA_W is a multiple of BYTE_W. Reset: upper limit all ones, lower all zeros.
module adc_win_limits
    import adc_win_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8,
    localparam int NBYTES = DATA_W / BYTE_W,
    localparam int AW     = $clog2(NUM_LIMS * NBYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [DATA_W-1:0] above_lim,
    output logic [DATA_W-1:0] below_lim
);
    logic [NUM_LIMS-1:0][DATA_W-1:0] lim_w;

    for (genvar l = 0; l < NUM_LIMS; l++) begin : g_lim
        for (genvar b = 0; b < NBYTES; b++) begin : g_byte
            localparam logic [AW-1:0]     MY_ADDR = AW'(l * NBYTES + b);
            localparam logic [BYTE_W-1:0] RST_V   = (l == LIM_ABOVE) ? '1 : '0;
            logic [BYTE_W-1:0] byte_q;

            // Purpose: hold one limit byte, load it when addressed.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    byte_q <= RST_V;
                else if (wr_en && (wr_addr == MY_ADDR))
                    byte_q <= wr_data;
            end

            assign lim_w[l][b*BYTE_W +: BYTE_W] = byte_q;
        end
    end

    assign above_lim = lim_w[LIM_ABOVE];
    assign below_lim = lim_w[LIM_BELOW];
endmodule

// File: rtl/adc_win_compare.sv
// Module: combinational window test of one result against the two limits.
// The mode is chosen by limit order: below > above selects inside, else outside.
// Assumes unsigned results and limits.
module adc_win_compare
    import adc_win_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] result,
    input  logic [DATA_W-1:0] above_lim,
    input  logic [DATA_W-1:0] below_lim,
    output win_mode_e         mode,
    output logic              match
);
    logic over_above;
    logic under_below;

    // Purpose: derive the window sense and the match for the current result.
    always_comb begin
        over_above  = result > above_lim;
        under_below = result < below_lim;
        mode        = (below_lim > above_lim) ? WIN_INSIDE : WIN_OUTSIDE;
        if (mode == WIN_INSIDE)
            match = over_above && under_below;
        else
            match = over_above || under_below;
    end
endmodule

// File: rtl/adc_win_flag.sv
// Module: sticky match flag. A set takes priority over a clear in the same cycle.
// Assumes `hit` is already qualified by the result strobe.
module adc_win_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic clr,
    output logic flag
);
    // Purpose: set on hit, clear on clr, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (hit)
            flag <= 1'b1;
        else if (clr)
            flag <= 1'b0;
    end
endmodule

// File: rtl/adc_window_cmp.sv
// Module: top of the ADC window comparator. It stores the limits, compares each
// strobed result with them, keeps a sticky flag and gates it onto the interrupt.
// Assumes res_valid is high for one cycle per conversion result.
module adc_window_cmp
    import adc_win_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8,
    localparam int NBYTES = DATA_W / BYTE_W,
    localparam int AW     = $clog2(NUM_LIMS * NBYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] res_data,
    input  logic              res_valid,
    input  logic              lim_wr_en,
    input  logic [AW-1:0]     lim_wr_addr,
    input  logic [BYTE_W-1:0] lim_wr_data,
    input  logic              flag_clr,
    input  logic              irq_en,
    output logic              win_flag,
    output logic              win_irq
);
    logic [DATA_W-1:0] above_lim;
    logic [DATA_W-1:0] below_lim;
    win_mode_e         win_mode;
    logic              win_match;
    logic              win_hit;

    adc_win_limits #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_limits (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (lim_wr_en),
        .wr_addr   (lim_wr_addr),
        .wr_data   (lim_wr_data),
        .above_lim (above_lim),
        .below_lim (below_lim)
    );

    adc_win_compare #(.DATA_W(DATA_W)) u_compare (
        .result    (res_data),
        .above_lim (above_lim),
        .below_lim (below_lim),
        .mode      (win_mode),
        .match     (win_match)
    );

    assign win_hit = res_valid && win_match;

    adc_win_flag u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (win_hit),
        .clr   (flag_clr),
        .flag  (win_flag)
    );

    assign win_irq = win_flag && irq_en;
endmodule

// File: rtl/adc_window_chk.sv
// Module: assertion checker for adc_window_cmp, attached by bind.
// Assumes it sees the stored limits through the top's internal limit nets.
module adc_window_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] res_data,
    input logic              res_valid,
    input logic              flag_clr,
    input logic              irq_en,
    input logic              win_flag,
    input logic              win_irq,
    input logic [DATA_W-1:0] above_lim,
    input logic [DATA_W-1:0] below_lim
);
    // R6: the flag holds while no clear is requested
    p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (win_flag && !flag_clr) |=> win_flag);

    // R6: a clear without a strobe empties the flag
    p_flag_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !res_valid) |=> !win_flag);

    // R5: no strobe means the flag cannot rise
    p_no_set_without_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_flag && !res_valid) |=> !win_flag);

    // R3: an inside-mode result strictly between the limits sets the flag
    p_inside_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && (below_lim > above_lim) && (res_data > above_lim)
         && (res_data < below_lim)) |=> win_flag);

    // R4: an outside-mode result past either limit sets the flag
    p_outside_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && (below_lim <= above_lim)
         && ((res_data < below_lim) || (res_data > above_lim))) |=> win_flag);

    // R9: the interrupt never fires without both flag and enable
    p_irq_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        win_irq |-> (win_flag && irq_en));
endmodule

bind adc_window_cmp adc_window_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .res_data  (res_data),
    .res_valid (res_valid),
    .flag_clr  (flag_clr),
    .irq_en    (irq_en),
    .win_flag  (win_flag),
    .win_irq   (win_irq),
    .above_lim (above_lim),
    .below_lim (below_lim)
);

// File: tb/adc_window_cmp_tb.sv
module adc_window_cmp_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] res_data = '0;
    logic        res_valid = 1'b0;
    logic        lim_wr_en = 1'b0;
    logic [1:0]  lim_wr_addr = '0;
    logic [7:0]  lim_wr_data = '0;
    logic        flag_clr = 1'b0;
    logic        irq_en = 1'b0;
    logic        win_flag;
    logic        win_irq;

    int total = 0;
    int bad = 0;

    // behavioural reference state
    logic [15:0] m_above;
    logic [15:0] m_below;
    logic        m_flag;

    always #2.5 clk = ~clk;   // 200 MHz

    adc_window_cmp u_dut (
        .clk(clk), .rst_n(rst_n), .res_data(res_data), .res_valid(res_valid),
        .lim_wr_en(lim_wr_en), .lim_wr_addr(lim_wr_addr), .lim_wr_data(lim_wr_data),
        .flag_clr(flag_clr), .irq_en(irq_en), .win_flag(win_flag), .win_irq(win_irq)
    );

    // one clock: update the model from the inputs held over the edge, then compare
    task automatic step(input string tag);
        logic hit;
        @(posedge clk);
        if (!rst_n) begin
            m_above = 16'hFFFF; m_below = 16'h0000; m_flag = 1'b0;
        end else begin
            hit = 1'b0;
            if (res_valid) begin
                if (m_below > m_above)
                    hit = (res_data > m_above) && (res_data < m_below);
                else
                    hit = (res_data < m_below) || (res_data > m_above);
            end
            if (hit) m_flag = 1'b1;
            else if (flag_clr) m_flag = 1'b0;
            if (lim_wr_en) begin
                case (lim_wr_addr)
                    2'd0: m_above[7:0]  = lim_wr_data;
                    2'd1: m_above[15:8] = lim_wr_data;
                    2'd2: m_below[7:0]  = lim_wr_data;
                    default: m_below[15:8] = lim_wr_data;
                endcase
            end
        end
        @(negedge clk);
        total++;
        if (win_flag !== m_flag) begin
            bad++;
            $display("FAIL %s flag: actual=%0b expected=%0b", tag, win_flag, m_flag);
        end
        total++;
        if (win_irq !== (m_flag && irq_en)) begin
            bad++;
            $display("FAIL %s irq: actual=%0b expected=%0b", tag, win_irq, m_flag && irq_en);
        end
    endtask

    task automatic set_lims(input logic [15:0] above, input logic [15:0] below, input string tag);
        for (int i = 0; i < 4; i++) begin
            lim_wr_en   = 1'b1;
            lim_wr_addr = 2'(i);
            lim_wr_data = (i == 0) ? above[7:0] : (i == 1) ? above[15:8] :
                          (i == 2) ? below[7:0] : below[15:8];
            step(tag);
        end
        lim_wr_en = 1'b0;
    endtask

    task automatic send(input logic [15:0] v, input string tag);
        res_data = v; res_valid = 1'b1;
        step(tag);
        res_valid = 1'b0;
        step(tag);
    endtask

    task automatic clear(input string tag);
        flag_clr = 1'b1;
        step(tag);
        flag_clr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] lfsr;
        @(negedge clk);
        rst_n = 1'b0;
        step("R1 reset"); step("R1 reset");
        rst_n = 1'b1;
        step("R1 idle");
        // R1: reset limits cannot match anything
        send(16'h0000, "R1 zero"); send(16'h8000, "R1 mid"); send(16'hFFFF, "R1 max");

        // R2/R3: inside window 0x1000 < r < 0x2000
        irq_en = 1'b1;
        set_lims(16'h1000, 16'h2000, "R2 write inside");
        send(16'h1000, "R3 on above edge");
        send(16'h2000, "R3 on below edge");
        send(16'h0FFF, "R3 outside low");
        send(16'h1001, "R3 just inside");
        clear("R6 clear");
        send(16'h1FFF, "R3 just inside top");
        // R9: enable gates irq
        irq_en = 1'b0; step("R9 irq off");
        irq_en = 1'b1; step("R9 irq on");
        // R6: sticky over idle cycles and a non-matching strobe
        send(16'h3000, "R6 sticky");
        repeat (3) step("R6 hold");
        clear("R6 clear");

        // R5: matching data without strobe
        res_data = 16'h1800;
        repeat (3) step("R5 no strobe");

        // R7: clear together with a match
        res_data = 16'h1800; res_valid = 1'b1; flag_clr = 1'b1;
        step("R7 clear vs set");
        res_valid = 1'b0; flag_clr = 1'b0;
        step("R7 after");
        clear("R7 clear");

        // R4: outside mode, below 0x1000, above 0x3000
        set_lims(16'h3000, 16'h1000, "R2 write outside");
        send(16'h2000, "R4 inside no match");
        send(16'h1000, "R4 on below edge");
        send(16'h3000, "R4 on above edge");
        send(16'h0FFF, "R4 under");
        clear("R4 clear");
        send(16'h3001, "R4 over");
        clear("R4 clear");

        // R10: equal limits
        set_lims(16'h5555, 16'h5555, "R10 write equal");
        send(16'h5555, "R10 on value");
        send(16'h5556, "R10 off value");
        clear("R10 clear");

        // R8: write in the same cycle as a strobe; limits are outside 0x1000/0x3000
        set_lims(16'h3000, 16'h1000, "R8 setup");
        res_data = 16'h2000; res_valid = 1'b1;
        lim_wr_en = 1'b1; lim_wr_addr = 2'd3; lim_wr_data = 8'h28;  // below becomes 0x2800
        step("R8 same cycle old limits");
        lim_wr_en = 1'b0;
        step("R8 still clear");
        res_valid = 1'b1;
        step("R8 next strobe new limits");
        res_valid = 1'b0;
        step("R8 set");
        clear("R8 clear");

        // mixed run against the model (R2 R3 R4 R5 R6 R7 R9)
        lfsr = 32'h1ACE_B00C;
        for (int i = 0; i < 2000; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            res_data    = lfsr[15:0];
            res_valid   = lfsr[16] & lfsr[17];
            flag_clr    = lfsr[18] & lfsr[19] & lfsr[20];
            irq_en      = lfsr[21] | lfsr[22];
            lim_wr_en   = (lfsr[23:26] == 4'b0000);
            lim_wr_addr = lfsr[28:27];
            lim_wr_data = lfsr[31:24];
            step("R3 R4 mixed");
        end
        res_valid = 1'b0; lim_wr_en = 1'b0; flag_clr = 1'b0;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule